// File: doc/BRIEF.md
# Debug Register Challenge-Response Lock

This block guards the register interface of a debug module. The interface is a simple register bus with an address, write data, a write strobe, a read strobe and read data. The block keeps a 32-bit challenge, a secret that is fixed at build time, and an authenticated flag. A host reads the challenge from a dedicated authentication register. It unlocks the module by writing back the challenge plus the secret, summed in 32 bits with wraparound. Every wrong answer locks the module and replaces the challenge with a new pseudo-random value. The new value comes from a free-running LFSR inside the block.

The block does not hold the other debug registers. It sends the rest of the debug module a gated write enable and a per-bit write mask, so each bus write is either passed through, narrowed, or rejected. While locked, only two writes do anything. A write to the authentication register is handled inside the block. A write to the control register reaches only the module-active bit. Every other write is refused, and the refusal is flagged in the same cycle. A build-time parameter can switch authentication off. The module then starts out unlocked, and writes to the authentication register are accepted but change nothing.

Top module: `dbg_auth_gate`

## Requirements
- R1: After reset, `authenticated` is 0 when `REQUIRE_AUTH` is 1 and is 1 when `REQUIRE_AUTH` is 0.
- R2: A read strobe at address `AUTH_ADDR` returns the current challenge on `reg_rdata` in the same cycle. A read at any other address returns 0 from this block.
- R3: With `REQUIRE_AUTH` = 1, a write to `AUTH_ADDR` whose data equals (challenge + `SECRET`) mod 2^32 sets `authenticated` from the next cycle on.
- R4: With `REQUIRE_AUTH` = 1, a write to `AUTH_ADDR` with any other data clears `authenticated` from the next cycle on. It also loads a new challenge that differs from the previous one, and this applies even if the module was already unlocked.
- R5: While `authenticated` is 0, a write to any address other than `AUTH_ADDR` and `CTRL_ADDR` gives `fwd_wr_en` = 0 and `wr_fail` = 1 in the same cycle.
- R6: While `authenticated` is 0, a write to `CTRL_ADDR` gives `fwd_wr_en` = 1 with `fwd_wmask` holding only bit `ACTIVE_BIT` (bit 0 by default). Halt, resume and all other control fields are therefore left unchanged.
- R7: While `authenticated` is 1, a write to any address other than `AUTH_ADDR` gives `fwd_wr_en` = 1, `fwd_wmask` = all ones and `wr_fail` = 0.
- R8: A write to `AUTH_ADDR` is never forwarded (`fwd_wr_en` = 0) and never flagged as failed (`wr_fail` = 0).
- R9: With `REQUIRE_AUTH` = 0, writes to `AUTH_ADDR` leave both `authenticated` and the challenge unchanged.
- R10: The challenge changes only in the cycle after a wrong answer. Correct answers and all other traffic leave it as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Register address of the current access |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Challenge on a read of the authentication register, else 0 |
| authenticated | output | 1 | Unlock state |
| fwd_wr_en | output | 1 | Write enable passed to the rest of the debug module |
| fwd_wmask | output | 32 | Bits of the write data the rest of the module may apply |
| wr_fail | output | 1 | The current write was refused |

## Verification
The assertions assume that the host raises at most one strobe per cycle. They also assume that address and data stay steady while the write strobe is high, because the gate outputs are combinational views of the present write. The bench drives every access on the falling edge and holds it for exactly one clock, never with both strobes high. It computes each unlock value from the challenge it has just read, so the assertions' view of the challenge always matches the one the host answered.

// File: rtl/dbg_auth_pkg.sv
// Package dbg_auth_pkg
// Shared types and helpers for the debug challenge-response lock.
// Assumes a 32-bit challenge and register data path.
package dbg_auth_pkg;

    localparam int CHAL_W = 32;

    // How a single bus write is routed by the gate.
    typedef enum logic [1:0] {
        ROUTE_BLOCK  = 2'd0,
        ROUTE_ACTIVE = 2'd1,
        ROUTE_FULL   = 2'd2,
        ROUTE_LOCAL  = 2'd3
    } wr_route_e;

    // One step of a right-shifting Galois LFSR with the given tap mask.
    function automatic logic [CHAL_W-1:0] lfsr_step(
        input logic [CHAL_W-1:0] cur,
        input logic [CHAL_W-1:0] taps
    );
        lfsr_step = cur[0] ? ((cur >> 1) ^ taps) : (cur >> 1);
    endfunction

endpackage

// File: rtl/dbg_auth_lfsr.sv
// Module dbg_auth_lfsr
// Free-running pseudo-random source that steps every clock.
// Assumes TAPS describes a maximal-length polynomial and SEED is nonzero,
// so the state never reaches zero.
module dbg_auth_lfsr
    import dbg_auth_pkg::*;
#(
    parameter logic [CHAL_W-1:0] TAPS = 32'h8020_0003,
    parameter logic [CHAL_W-1:0] SEED = 32'h1ACE_B00C
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [CHAL_W-1:0] rnd
);

    logic [CHAL_W-1:0] state_q;

    // Advance the generator once per cycle; reload the seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else begin
            state_q <= lfsr_step(state_q, TAPS);
        end
    end

    assign rnd = state_q;

endmodule

// File: rtl/dbg_auth_state.sv
// Module dbg_auth_state
// Holds the challenge and the authenticated flag. It checks each write
// to the authentication register against challenge + SECRET (wrapping).
// Assumes auth_wr is high for at most one cycle per bus write.
module dbg_auth_state
    import dbg_auth_pkg::*;
#(
    parameter bit                REQUIRE_AUTH = 1'b1,
    parameter logic [CHAL_W-1:0] SECRET       = 32'h5EC2_E7A1,
    parameter logic [CHAL_W-1:0] RESET_CHAL   = 32'h1ACE_B00C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auth_wr,
    input  logic [CHAL_W-1:0] auth_wdata,
    input  logic [CHAL_W-1:0] rnd,
    output logic              authed,
    output logic [CHAL_W-1:0] challenge
);

    localparam logic START_AUTHED = !REQUIRE_AUTH;

    logic [CHAL_W-1:0] answer;
    logic              answer_ok;

    // Expected unlock word and the comparison against the bus data.
    always_comb begin
        answer    = challenge + SECRET;
        answer_ok = (auth_wdata == answer);
    end

    // Update flag and challenge on an answer; ignore answers when open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            authed    <= START_AUTHED;
            challenge <= RESET_CHAL;
        end else if (REQUIRE_AUTH && auth_wr) begin
            if (answer_ok) begin
                authed <= 1'b1;
            end else begin
                authed    <= 1'b0;
                challenge <= rnd;
            end
        end
    end

endmodule

// File: rtl/dbg_auth_wgate.sv
// Module dbg_auth_wgate
// Decides, from the address and the unlock state, how a write is routed:
// kept local, passed with a full mask, narrowed to the module-active bit,
// or refused. Purely combinational.
// Assumes AUTH_ADDR differs from CTRL_ADDR.
module dbg_auth_wgate
    import dbg_auth_pkg::*;
#(
    parameter int                ADDR_W     = 7,
    parameter logic [ADDR_W-1:0] AUTH_ADDR  = 7'h30,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 7'h10,
    parameter int                ACTIVE_BIT = 0
) (
    input  logic              authed,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output logic              auth_wr,
    output logic              fwd_wr_en,
    output logic [CHAL_W-1:0] fwd_wmask,
    output logic              wr_fail
);

    localparam logic [CHAL_W-1:0] ACTIVE_MASK = CHAL_W'(1) << ACTIVE_BIT;

    wr_route_e route;
    logic      hit_auth;
    logic      hit_ctrl;

    // Address decode for the two registers that stay writable when locked.
    always_comb begin
        hit_auth = (addr == AUTH_ADDR);
        hit_ctrl = (addr == CTRL_ADDR);
    end

    // Choose the route for the present address and lock state.
    always_comb begin
        if (hit_auth) begin
            route = ROUTE_LOCAL;
        end else if (authed) begin
            route = ROUTE_FULL;
        end else if (hit_ctrl) begin
            route = ROUTE_ACTIVE;
        end else begin
            route = ROUTE_BLOCK;
        end
    end

    // Turn the route into strobes and a mask, qualified by the write strobe.
    always_comb begin
        auth_wr   = 1'b0;
        fwd_wr_en = 1'b0;
        fwd_wmask = '0;
        wr_fail   = 1'b0;
        if (wr) begin
            unique case (route)
                ROUTE_LOCAL: begin
                    auth_wr = 1'b1;
                end
                ROUTE_FULL: begin
                    fwd_wr_en = 1'b1;
                    fwd_wmask = '1;
                end
                ROUTE_ACTIVE: begin
                    fwd_wr_en = 1'b1;
                    fwd_wmask = ACTIVE_MASK;
                end
                default: begin
                    wr_fail = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/dbg_auth_gate.sv
// Module dbg_auth_gate
// Top of the challenge-response lock for a debug register interface.
// It ties together the random source, the lock state and the write gate,
// and it serves reads of the authentication register.
// Assumes at most one of reg_wr / reg_rd is high in a cycle.
module dbg_auth_gate
    import dbg_auth_pkg::*;
#(
    parameter bit                REQUIRE_AUTH = 1'b1,
    parameter logic [CHAL_W-1:0] SECRET       = 32'h5EC2_E7A1,
    parameter logic [CHAL_W-1:0] LFSR_SEED    = 32'h1ACE_B00C,
    parameter logic [CHAL_W-1:0] LFSR_TAPS    = 32'h8020_0003,
    parameter int                ADDR_W       = 7,
    parameter logic [ADDR_W-1:0] AUTH_ADDR    = 7'h30,
    parameter logic [ADDR_W-1:0] CTRL_ADDR    = 7'h10,
    parameter int                ACTIVE_BIT   = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CHAL_W-1:0] reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [CHAL_W-1:0] reg_rdata,
    output logic              authenticated,
    output logic              fwd_wr_en,
    output logic [CHAL_W-1:0] fwd_wmask,
    output logic              wr_fail
);

    logic [CHAL_W-1:0] rnd;
    logic [CHAL_W-1:0] challenge;
    logic              auth_wr;

    dbg_auth_lfsr #(
        .TAPS (LFSR_TAPS),
        .SEED (LFSR_SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd)
    );

    dbg_auth_state #(
        .REQUIRE_AUTH (REQUIRE_AUTH),
        .SECRET       (SECRET),
        .RESET_CHAL   (LFSR_SEED)
    ) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .auth_wr    (auth_wr),
        .auth_wdata (reg_wdata),
        .rnd        (rnd),
        .authed     (authenticated),
        .challenge  (challenge)
    );

    dbg_auth_wgate #(
        .ADDR_W     (ADDR_W),
        .AUTH_ADDR  (AUTH_ADDR),
        .CTRL_ADDR  (CTRL_ADDR),
        .ACTIVE_BIT (ACTIVE_BIT)
    ) u_wgate (
        .authed    (authenticated),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .auth_wr   (auth_wr),
        .fwd_wr_en (fwd_wr_en),
        .fwd_wmask (fwd_wmask),
        .wr_fail   (wr_fail)
    );

    // Serve the challenge on reads of the authentication register.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd && (reg_addr == AUTH_ADDR)) begin
            reg_rdata = challenge;
        end
    end

endmodule

// File: rtl/dbg_auth_gate_chk.sv
// Module dbg_auth_gate_chk
// Assertion checker bound to dbg_auth_gate. It relates the bus inputs,
// the lock state and the gate outputs over time.
// Assumes the same parameter values as the instance it is bound to.
module dbg_auth_gate_chk
    import dbg_auth_pkg::*;
#(
    parameter bit                REQUIRE_AUTH = 1'b1,
    parameter logic [CHAL_W-1:0] SECRET       = 32'h5EC2_E7A1,
    parameter int                ADDR_W       = 7,
    parameter logic [ADDR_W-1:0] AUTH_ADDR    = 7'h30,
    parameter logic [ADDR_W-1:0] CTRL_ADDR    = 7'h10,
    parameter int                ACTIVE_BIT   = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [CHAL_W-1:0] reg_wdata,
    input logic              reg_wr,
    input logic              authenticated,
    input logic              fwd_wr_en,
    input logic [CHAL_W-1:0] fwd_wmask,
    input logic              wr_fail,
    input logic [CHAL_W-1:0] challenge
);

    localparam logic [CHAL_W-1:0] ACT_MASK = CHAL_W'(1) << ACTIVE_BIT;

    assert_reset_flag_R1: assert property (@(posedge clk)
        !rst_n |=> (authenticated == (REQUIRE_AUTH == 1'b0)));

    assert_unlock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (REQUIRE_AUTH && reg_wr && reg_addr == AUTH_ADDR
         && reg_wdata == challenge + SECRET) |=> authenticated);

    assert_wrong_locks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (REQUIRE_AUTH && reg_wr && reg_addr == AUTH_ADDR
         && reg_wdata != challenge + SECRET)
        |=> (!authenticated && challenge != $past(challenge)));

    assert_locked_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!authenticated && reg_wr && reg_addr != AUTH_ADDR && reg_addr != CTRL_ADDR)
        |-> (!fwd_wr_en && wr_fail));

    assert_locked_ctrl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!authenticated && reg_wr && reg_addr == CTRL_ADDR)
        |-> (fwd_wr_en && fwd_wmask == ACT_MASK && !wr_fail));

    assert_open_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (authenticated && reg_wr && reg_addr != AUTH_ADDR)
        |-> (fwd_wr_en && fwd_wmask == '1 && !wr_fail));

    assert_auth_local_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == AUTH_ADDR) |-> (!fwd_wr_en && !wr_fail));

    assert_open_build_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!REQUIRE_AUTH) |-> authenticated);

    assert_chal_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == AUTH_ADDR && reg_wdata != challenge + SECRET)
        |=> $stable(challenge));

endmodule

bind dbg_auth_gate dbg_auth_gate_chk #(
    .REQUIRE_AUTH (REQUIRE_AUTH),
    .SECRET       (SECRET),
    .ADDR_W       (ADDR_W),
    .AUTH_ADDR    (AUTH_ADDR),
    .CTRL_ADDR    (CTRL_ADDR),
    .ACTIVE_BIT   (ACTIVE_BIT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_wr        (reg_wr),
    .authenticated (authenticated),
    .fwd_wr_en     (fwd_wr_en),
    .fwd_wmask     (fwd_wmask),
    .wr_fail       (wr_fail),
    .challenge     (challenge)
);

// File: tb/dbg_auth_gate_tb.sv
// Directed bench for dbg_auth_gate: one locked build (u_dut) and one
// build with authentication switched off (u_dut_open) share the bus.
module dbg_auth_gate_tb;

    localparam time         CLK_PERIOD = 10ns;
    localparam int          AW         = 7;
    localparam logic [31:0] SECRET     = 32'hC0DE_1234;
    localparam logic [AW-1:0] A_AUTH   = 7'h30;
    localparam logic [AW-1:0] A_CTRL   = 7'h10;
    localparam logic [AW-1:0] A_OTHER  = 7'h04;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;

    logic [31:0] rdata, wmask, rdata_o, wmask_o;
    logic        authed, fwd_en, fail, authed_o, fwd_en_o, fail_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Values captured during the last write.
    logic        s_fwd, s_fail, s_fwd_o;
    logic [31:0] s_mask, s_mask_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_auth_gate #(
        .REQUIRE_AUTH (1'b1), .SECRET (SECRET), .LFSR_SEED (32'h1ACE_B00C),
        .ADDR_W (AW), .AUTH_ADDR (A_AUTH), .CTRL_ADDR (A_CTRL), .ACTIVE_BIT (0)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
        .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_rdata (rdata),
        .authenticated (authed), .fwd_wr_en (fwd_en), .fwd_wmask (wmask),
        .wr_fail (fail)
    );

    dbg_auth_gate #(
        .REQUIRE_AUTH (1'b0), .SECRET (SECRET), .LFSR_SEED (32'h0BAD_F00D),
        .ADDR_W (AW), .AUTH_ADDR (A_AUTH), .CTRL_ADDR (A_CTRL), .ACTIVE_BIT (0)
    ) u_dut_open (
        .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
        .reg_wr (reg_wr), .reg_rd (reg_rd), .reg_rdata (rdata_o),
        .authenticated (authed_o), .fwd_wr_en (fwd_en_o), .fwd_wmask (wmask_o),
        .wr_fail (fail_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-cycle write; gate outputs captured mid-cycle, state valid on return.
    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        #1;
        s_fwd = fwd_en; s_fail = fail; s_mask = wmask;
        s_fwd_o = fwd_en_o; s_mask_o = wmask_o;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] v, output logic [31:0] vo);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1;
        v = rdata; vo = rdata_o;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    logic [31:0] ch0, ch1, ch2, open_ch;

    task automatic t_reset();
        check("R1 locked build starts locked", 32'(authed), 32'd0);
        check("R1 open build starts unlocked", 32'(authed_o), 32'd1);
    endtask

    task automatic t_read();
        logic [31:0] v, vo, v2, vo2;
        bus_read(A_AUTH, v, vo);
        ch0 = v; open_ch = vo;
        check("R2 reset challenge readable", v, 32'h1ACE_B00C);
        bus_read(A_OTHER, v2, vo2);
        check("R2 other address reads zero", v2, 32'd0);
        bus_read(A_AUTH, v2, vo2);
        check("R10 challenge steady across idle reads", v2, ch0);
    endtask

    task automatic t_lockout();
        bus_write(A_OTHER, 32'hFFFF_FFFF);
        check("R5 locked write not forwarded", 32'(s_fwd), 32'd0);
        check("R5 locked write flagged", 32'(s_fail), 32'd1);
        bus_write(A_CTRL, 32'hFFFF_FFFF);
        check("R6 locked ctrl write forwarded", 32'(s_fwd), 32'd1);
        check("R6 locked ctrl mask active bit only", s_mask, 32'h1);
        bus_write(A_AUTH, ch0 + SECRET + 32'd1);
        check("R8 auth write not forwarded", 32'(s_fwd), 32'd0);
        check("R8 auth write not flagged", 32'(s_fail), 32'd0);
        check("R4 wrong answer keeps lock", 32'(authed), 32'd0);
    endtask

    task automatic t_rechallenge();
        logic [31:0] v, vo;
        bus_read(A_AUTH, v, vo);
        ch1 = v;
        checks++;
        if (ch1 == ch0) begin
            failures++;
            $display("FAIL R4 challenge not replaced actual=%h expected!=%h", ch1, ch0);
        end
    endtask

    task automatic t_unlock();
        logic [31:0] v, vo;
        bus_write(A_AUTH, ch1 + SECRET);
        check("R3 correct answer unlocks", 32'(authed), 32'd1);
        bus_read(A_AUTH, v, vo);
        check("R10 correct answer keeps challenge", v, ch1);
        bus_write(A_OTHER, 32'h1234_5678);
        check("R7 unlocked write forwarded", 32'(s_fwd), 32'd1);
        check("R7 unlocked full mask", s_mask, 32'hFFFF_FFFF);
        check("R7 unlocked write not flagged", 32'(s_fail), 32'd0);
        bus_write(A_CTRL, 32'h8000_0001);
        check("R7 unlocked ctrl full mask", s_mask, 32'hFFFF_FFFF);
    endtask

    task automatic t_relock();
        logic [31:0] v, vo;
        bus_write(A_AUTH, ch1 + SECRET - 32'd1);
        check("R4 wrong answer relocks", 32'(authed), 32'd0);
        bus_read(A_AUTH, v, vo);
        ch2 = v;
        checks++;
        if (ch2 == ch1) begin
            failures++;
            $display("FAIL R4 challenge not replaced after relock actual=%h expected!=%h", ch2, ch1);
        end
        bus_write(A_OTHER, 32'h0);
        check("R5 relocked write refused", 32'(s_fail), 32'd1);
        bus_write(A_AUTH, ch2 + SECRET);
        check("R3 second unlock with wrapped sum", 32'(authed), 32'd1);
    endtask

    task automatic t_open();
        logic [31:0] v, vo;
        bus_write(A_AUTH, 32'hDEAD_BEEF);
        check("R9 open build stays unlocked", 32'(authed_o), 32'd1);
        bus_read(A_AUTH, v, vo);
        check("R9 open build challenge unchanged", vo, open_ch);
        bus_write(A_OTHER, 32'h5);
        check("R7 open build forwards", 32'(s_fwd_o), 32'd1);
        check("R7 open build full mask", s_mask_o, 32'hFFFF_FFFF);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_read();
        t_lockout();
        t_rechallenge();
        t_unlock();
        t_relock();
        t_open();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule